// File: doc/BRIEF.md
# SDRAM Command Bus Protocol Monitor

This block is a passive observer for a single-data-rate SDRAM command bus. On every rising clock it samples clock enable, chip select, the row strobe, the column strobe, write enable, the two bank-select bits, address bit 10 and the data mask. From these it decodes one command per cycle. It tracks each of the four banks as closed, open, or cooling down after an auto-precharge burst. It also follows self-refresh. It never drives the bus.

When a command breaks a bank-state, auto-precharge or idle-state rule, the block latches an error flag together with a code that names the rule. The flag and code stay until reset. In parallel it follows write and read data bursts, using a fixed burst length and CAS latency set by parameters. Per beat it reports whether that beat was masked: write data is masked by the mask bit sampled in the same clock, and read data by the mask bit sampled two clocks earlier.

All outputs are registered. Each updates at the clock edge that samples the command or beat it describes, and is visible after that edge.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: The bank select maps onto the bank bits of `bank_open_o` as follows: ba_i=00 maps to bit 0, ba_i=10 (ba_i[1] high) to bit 1, ba_i=01 (ba_i[0] high) to bit 2, and ba_i=11 to bit 3.
- R2: A cycle is decoded as no command, and changes no state and flags no error, when either cs_ni is high or cke_i was low at the previous sampling edge. Command encodings on {ras_ni,cas_ni,we_ni} are: 011 activate, 101 read, 100 write, 010 precharge, 000 mode set, 001 refresh.
- R3: Activate sets the bank's open bit. Precharge clears it, for all banks when a10_i is high. A read or write with a10_i high clears the bank's bit at the command edge.
- R4: A write command starts BURST_LEN write beats, the first in the same cycle. `wr_beat_o` is high for each beat. `wr_mask_o` is high when dqm_i was high in that same beat's cycle.
- R5: A read command at cycle t gives beats at cycles t+CAS_LAT to t+CAS_LAT+BURST_LEN-1, flagged on `rd_beat_o`. A beat at cycle c is masked (`rd_mask_o`) when dqm_i was high at cycle c-2.
- R6: A read or write to a bank whose open bit is clear raises error code 1.
- R7: Activate to a bank whose open bit is set raises error code 2.
- R8: After a read or write with auto-precharge at cycle t, any read or write before cycle t+BURST_LEN raises error code 3. This check takes priority over R6.
- R9: After a read or write with auto-precharge at cycle t, activate to that bank before cycle t+BURST_LEN+T_RP raises error code 4. From that cycle on it is legal.
- R10: All banks are idle when no bank is open and no bank is cooling down. A mode set, auto refresh (cke_i high) or self-refresh entry (cke_i low) issued when the banks are not all idle raises code 5, 6 or 7 respectively.
- R11: `sref_o` rises at a self-refresh entry. It falls at the first edge where cke_i is high after it was low.
- R12: After reset `error_o` is 0 and `err_code_o` is 0. The first error sets `error_o` and its code. Neither changes again until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, rising edge samples |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Clock enable |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank select |
| a10_i | input | 1 | Auto-precharge / all-banks bit |
| dqm_i | input | 1 | Data mask |
| error_o | output | 1 | Sticky protocol error |
| err_code_o | output | 4 | Code of first error |
| bank_open_o | output | 4 | Open-row flag per bank |
| sref_o | output | 1 | Self-refresh in progress |
| wr_beat_o | output | 1 | A write beat was sampled |
| wr_mask_o | output | 1 | That write beat was masked |
| rd_beat_o | output | 1 | A read beat was sampled |
| rd_mask_o | output | 1 | That read beat was masked |

## Verification
The hardest situations to reach are the edges of the auto-precharge windows. A read to another bank exactly one cycle too early or just in time, and an activate one cycle before or exactly at the end of cooldown, differ only in how many idle cycles sit between two commands. The stimulus places the second command at an exact cycle count after the auto-precharge command and tries both sides of each boundary. The read-mask alignment is reached the same way: a different mask value is driven in each of the cycles following a read, so that a mask latency off by one would move the reported pattern.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;
  localparam int NUM_BANKS = 4;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_MRS, CMD_REF, CMD_SREF, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE
  } cmd_e;

  typedef enum logic [3:0] {
    ERR_NONE      = 4'd0,
    ERR_RW_CLOSED = 4'd1,
    ERR_ACT_OPEN  = 4'd2,
    ERR_RW_IN_AP  = 4'd3,
    ERR_ACT_EARLY = 4'd4,
    ERR_MRS_BUSY  = 4'd5,
    ERR_REF_BUSY  = 4'd6,
    ERR_SREF_BUSY = 4'd7
  } err_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic       cke_q_i,
  input  logic       cke_i,
  input  logic       cs_ni,
  input  logic       ras_ni,
  input  logic       cas_ni,
  input  logic       we_ni,
  input  logic [1:0] ba_i,
  output cmd_e       cmd_o,
  output logic [1:0] bank_o
);
  // bank bit order is A,B,C,D; ba_i[0] selects the upper pair
  assign bank_o = {ba_i[0], ba_i[1]};

  always_comb begin
    cmd_o = CMD_NOP;
    if (cke_q_i && !cs_ni) begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b000:  cmd_o = CMD_MRS;
        3'b001:  cmd_o = cke_i ? CMD_REF : CMD_SREF;
        3'b010:  cmd_o = CMD_PRE;
        3'b011:  cmd_o = CMD_ACT;
        3'b100:  cmd_o = CMD_WR;
        3'b101:  cmd_o = CMD_RD;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track #(
  parameter int COOL  = 6,
  parameter int CNT_W = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic close_i,
  input  logic ap_i,
  output logic open_o,
  output logic ready_o
);
  logic             open_q;
  logic [CNT_W-1:0] cool_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      cool_q <= '0;
    end else if (act_i) begin
      open_q <= 1'b1;
      cool_q <= '0;
    end else if (ap_i) begin
      open_q <= 1'b0;
      cool_q <= CNT_W'(COOL - 1);
    end else begin
      if (close_i) open_q <= 1'b0;
      if (cool_q != '0) cool_q <= cool_q - 1'b1;
    end
  end

  assign open_o  = open_q;
  assign ready_o = (cool_q == '0);

  a_r3_open_needs_act: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_q) |-> $past(act_i));
  a_r9_ap_starts_cool: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ap_i && !act_i) |=> (!open_q && !ready_o));
endmodule

// File: rtl/sdram_mask_track.sv
module sdram_mask_track #(
  parameter int BURST_LEN = 4,
  parameter int CAS_LAT   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_cmd_i,
  input  logic rd_cmd_i,
  input  logic dqm_i,
  output logic wr_beat_o,
  output logic wr_mask_o,
  output logic rd_beat_o,
  output logic rd_mask_o
);
  localparam int BW = $clog2(BURST_LEN + 1);

  logic [BW-1:0]      wr_cnt_q, rd_cnt_q;
  logic [CAS_LAT-1:0] rd_sr_q, rd_sr_d;
  logic [1:0]         dqm_hist_q;
  logic               wr_hit, rd_hit;
  logic               wr_beat_q, wr_mask_q, rd_beat_q, rd_mask_q;

  generate
    if (CAS_LAT == 1) begin : g_cl1
      assign rd_sr_d = rd_cmd_i;
    end else begin : g_cln
      assign rd_sr_d = {rd_sr_q[CAS_LAT-2:0], rd_cmd_i};
    end
  endgenerate

  assign wr_hit = wr_cmd_i | (wr_cnt_q != '0);
  assign rd_hit = rd_sr_q[CAS_LAT-1] | (rd_cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_cnt_q   <= '0;
      rd_cnt_q   <= '0;
      rd_sr_q    <= '0;
      dqm_hist_q <= '0;
      wr_beat_q  <= 1'b0;
      wr_mask_q  <= 1'b0;
      rd_beat_q  <= 1'b0;
      rd_mask_q  <= 1'b0;
    end else begin
      dqm_hist_q <= {dqm_hist_q[0], dqm_i};
      rd_sr_q    <= rd_sr_d;
      if (wr_cmd_i)             wr_cnt_q <= BW'(BURST_LEN - 1);
      else if (wr_cnt_q != '0)  wr_cnt_q <= wr_cnt_q - 1'b1;
      if (rd_sr_q[CAS_LAT-1])   rd_cnt_q <= BW'(BURST_LEN - 1);
      else if (rd_cnt_q != '0)  rd_cnt_q <= rd_cnt_q - 1'b1;
      wr_beat_q <= wr_hit;
      wr_mask_q <= wr_hit & dqm_i;         // write mask latency 0
      rd_beat_q <= rd_hit;
      rd_mask_q <= rd_hit & dqm_hist_q[1]; // read mask latency 2
    end
  end

  assign wr_beat_o = wr_beat_q;
  assign wr_mask_o = wr_mask_q;
  assign rd_beat_o = rd_beat_q;
  assign rd_mask_o = rd_mask_q;

  a_r4_wr_mask_in_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask_o |-> wr_beat_o);
  a_r5_rd_mask_in_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_mask_o |-> rd_beat_o);
  a_r4_wr_cmd_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmd_i |=> wr_beat_o);
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int CAS_LAT   = 2,
  parameter int T_RP      = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cke_i,
  input  logic       cs_ni,
  input  logic       ras_ni,
  input  logic       cas_ni,
  input  logic       we_ni,
  input  logic [1:0] ba_i,
  input  logic       a10_i,
  input  logic       dqm_i,
  output logic       error_o,
  output logic [3:0] err_code_o,
  output logic [3:0] bank_open_o,
  output logic       sref_o,
  output logic       wr_beat_o,
  output logic       wr_mask_o,
  output logic       rd_beat_o,
  output logic       rd_mask_o
);
  localparam int COOL  = BURST_LEN + T_RP;
  localparam int CNT_W = $clog2(COOL + 1);
  localparam int BW    = $clog2(BURST_LEN + 1);

  cmd_e                 cmd;
  logic [1:0]           bank_idx;
  logic [NUM_BANKS-1:0] bank_hot, act_hot, close_hot, ap_hot, open_vec, ready_vec;
  logic                 cke_q, sref_q, err_q, is_rw, all_idle;
  logic [BW-1:0]        ap_burst_q;
  err_e                 code_q, err_next;

  sdram_cmd_decode i_decode (
    .cke_q_i (cke_q),
    .cke_i   (cke_i),
    .cs_ni   (cs_ni),
    .ras_ni  (ras_ni),
    .cas_ni  (cas_ni),
    .we_ni   (we_ni),
    .ba_i    (ba_i),
    .cmd_o   (cmd),
    .bank_o  (bank_idx)
  );

  assign is_rw     = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign bank_hot  = NUM_BANKS'(1) << bank_idx;
  assign act_hot   = (cmd == CMD_ACT) ? bank_hot : '0;
  assign close_hot = (cmd == CMD_PRE) ? (a10_i ? '1 : bank_hot) : '0;
  assign ap_hot    = (is_rw && a10_i) ? bank_hot : '0;

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      sdram_bank_track #(.COOL(COOL), .CNT_W(CNT_W)) i_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .act_i   (act_hot[b]),
        .close_i (close_hot[b]),
        .ap_i    (ap_hot[b]),
        .open_o  (open_vec[b]),
        .ready_o (ready_vec[b])
      );
    end
  endgenerate

  sdram_mask_track #(.BURST_LEN(BURST_LEN), .CAS_LAT(CAS_LAT)) i_mask (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_cmd_i  (cmd == CMD_WR),
    .rd_cmd_i  (cmd == CMD_RD),
    .dqm_i     (dqm_i),
    .wr_beat_o (wr_beat_o),
    .wr_mask_o (wr_mask_o),
    .rd_beat_o (rd_beat_o),
    .rd_mask_o (rd_mask_o)
  );

  assign all_idle = (open_vec == '0) && (&ready_vec);

  always_comb begin
    err_next = ERR_NONE;
    unique case (cmd)
      CMD_RD, CMD_WR: begin
        if (ap_burst_q != '0)        err_next = ERR_RW_IN_AP;
        else if (!open_vec[bank_idx]) err_next = ERR_RW_CLOSED;
      end
      CMD_ACT: begin
        if (!ready_vec[bank_idx])    err_next = ERR_ACT_EARLY;
        else if (open_vec[bank_idx]) err_next = ERR_ACT_OPEN;
      end
      CMD_MRS:  if (!all_idle) err_next = ERR_MRS_BUSY;
      CMD_REF:  if (!all_idle) err_next = ERR_REF_BUSY;
      CMD_SREF: if (!all_idle) err_next = ERR_SREF_BUSY;
      default:  err_next = ERR_NONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q      <= 1'b1;
      sref_q     <= 1'b0;
      err_q      <= 1'b0;
      code_q     <= ERR_NONE;
      ap_burst_q <= '0;
    end else begin
      cke_q <= cke_i;
      if (cmd == CMD_SREF)        sref_q <= 1'b1;
      else if (!cke_q && cke_i)   sref_q <= 1'b0;
      if (is_rw && a10_i)         ap_burst_q <= BW'(BURST_LEN - 1);
      else if (ap_burst_q != '0)  ap_burst_q <= ap_burst_q - 1'b1;
      if (!err_q && err_next != ERR_NONE) begin
        err_q  <= 1'b1;
        code_q <= err_next;
      end
    end
  end

  assign error_o     = err_q;
  assign err_code_o  = code_q;
  assign bank_open_o = open_vec;
  assign sref_o      = sref_q;

  a_r12_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> (error_o && $stable(err_code_o)));
  a_r6_rw_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_rw && !bank_open_o[bank_idx]) |=> error_o);
  a_r7_act_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd == CMD_ACT) && bank_open_o[bank_idx]) |=> error_o);
  a_r10_mrs_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd == CMD_MRS) && (bank_open_o != '0)) |=> error_o);
  a_r11_sref_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sref_o && !cke_q && cke_i) |=> !sref_o);
  a_r2_deselect_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && !error_o && !sref_o) |=> (!error_o && $stable(bank_open_o)));
endmodule

// File: tb/test_sdram_cmd_monitor.sv
module test_sdram_cmd_monitor;
  localparam int BL = 4, CL = 2, TRP = 2;
  localparam int K_ERR = 0, K_CODE = 1, K_OPEN = 2, K_WB = 3, K_WM = 4, K_RB = 5, K_RM = 6, K_SREF = 7;
  localparam logic [1:0] BA_A = 2'b00, BA_B = 2'b10, BA_C = 2'b01, BA_D = 2'b11;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cke_i = 1'b1, cs_ni = 1'b1, ras_ni = 1'b1, cas_ni = 1'b1, we_ni = 1'b1;
  logic [1:0] ba_i = 2'b00;
  logic a10_i = 1'b0, dqm_i = 1'b0;
  logic error_o, sref_o, wr_beat_o, wr_mask_o, rd_beat_o, rd_mask_o;
  logic [3:0] err_code_o, bank_open_o;

  typedef struct { int due; int kind; int val; string req; } exp_t;
  exp_t q[$];
  int cyc = 0, total = 0, bad = 0;

  sdram_cmd_monitor #(.BURST_LEN(BL), .CAS_LAT(CL), .T_RP(TRP)) i_sdram_cmd_monitor (
    .clk_i(clk_i), .rst_ni(rst_ni), .cke_i(cke_i), .cs_ni(cs_ni), .ras_ni(ras_ni),
    .cas_ni(cas_ni), .we_ni(we_ni), .ba_i(ba_i), .a10_i(a10_i), .dqm_i(dqm_i),
    .error_o(error_o), .err_code_o(err_code_o), .bank_open_o(bank_open_o), .sref_o(sref_o),
    .wr_beat_o(wr_beat_o), .wr_mask_o(wr_mask_o), .rd_beat_o(rd_beat_o), .rd_mask_o(rd_mask_o)
  );

  always #10 clk_i = ~clk_i;

  function automatic int get(int kind);
    case (kind)
      K_ERR:   return int'(error_o);
      K_CODE:  return int'(err_code_o);
      K_OPEN:  return int'(bank_open_o);
      K_WB:    return int'(wr_beat_o);
      K_WM:    return int'(wr_mask_o);
      K_RB:    return int'(rd_beat_o);
      K_RM:    return int'(rd_mask_o);
      default: return int'(sref_o);
    endcase
  endfunction

  task automatic chk(string req, int kind, int exp_v);
    int act_v = get(kind);
    total++;
    if (act_v != exp_v) begin
      bad++;
      $display("FAIL %s kind=%0d cyc=%0d actual=%0d expected=%0d", req, kind, cyc, act_v, exp_v);
    end
  endtask

  task automatic expect_at(int kind, int val, string req, int delay = 0);
    exp_t e;
    e.due = cyc + 1 + delay; e.kind = kind; e.val = val; e.req = req;
    q.push_back(e);
  endtask

  // monitor: pops expectations due at this edge
  initial forever begin
    @(posedge clk_i);
    cyc++;
    #5;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        chk(q[i].req, q[i].kind, q[i].val);
        q.delete(i);
      end
    end
  end

  task automatic drive(logic cke, logic cs, logic ras, logic cas, logic we,
                       logic [1:0] ba, logic a10, logic dqm);
    @(negedge clk_i);
    cke_i = cke; cs_ni = cs; ras_ni = ras; cas_ni = cas; we_ni = we;
    ba_i = ba; a10_i = a10; dqm_i = dqm;
  endtask

  task automatic nop(logic dqm = 1'b0);  drive(1, 1, 1, 1, 1, 2'b00, 0, dqm); endtask
  task automatic act(logic [1:0] ba);    drive(1, 0, 0, 1, 1, ba, 0, 0); endtask
  task automatic rd(logic [1:0] ba, logic ap, logic dqm = 1'b0); drive(1, 0, 1, 0, 1, ba, ap, dqm); endtask
  task automatic wr(logic [1:0] ba, logic ap, logic dqm = 1'b0); drive(1, 0, 1, 0, 0, ba, ap, dqm); endtask
  task automatic pre(logic [1:0] ba, logic all); drive(1, 0, 0, 1, 0, ba, all, 0); endtask
  task automatic mrs();                  drive(1, 0, 0, 0, 0, 2'b00, 0, 0); endtask
  task automatic aref();                 drive(1, 0, 0, 0, 1, 2'b00, 0, 0); endtask
  task automatic sref_in();              drive(0, 0, 0, 0, 1, 2'b00, 0, 0); endtask

  task automatic do_reset();
    repeat (8) nop();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R12 reset err", K_ERR, 0);
    chk("R12 reset code", K_CODE, 0);
    chk("R3 reset banks", K_OPEN, 0);
    chk("R11 reset sref", K_SREF, 0);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();

    // R1 bank mapping
    act(BA_C); expect_at(K_OPEN, 4'b0100, "R1 C");
    act(BA_B); expect_at(K_OPEN, 4'b0110, "R1 B");
    act(BA_A); expect_at(K_OPEN, 4'b0111, "R1 A");
    act(BA_D); expect_at(K_OPEN, 4'b1111, "R1 D"); expect_at(K_ERR, 0, "R7 legal acts");
    // R2 deselected precharge-all encoding
    drive(1, 1, 0, 1, 0, 2'b00, 1, 0);
    expect_at(K_OPEN, 4'b1111, "R2 cs high"); expect_at(K_ERR, 0, "R2 cs high");
    // R3 precharge
    pre(BA_B, 0); expect_at(K_OPEN, 4'b1101, "R3 single");
    pre(BA_A, 1); expect_at(K_OPEN, 4'b0000, "R3 all");
    // R4 write mask latency 0
    act(BA_A);
    wr(BA_A, 0, 0); expect_at(K_WB, 1, "R4"); expect_at(K_WM, 0, "R4");
    nop(1);         expect_at(K_WB, 1, "R4"); expect_at(K_WM, 1, "R4");
    nop(0);         expect_at(K_WB, 1, "R4"); expect_at(K_WM, 0, "R4");
    nop(1);         expect_at(K_WB, 1, "R4"); expect_at(K_WM, 1, "R4");
    nop(1);         expect_at(K_WB, 0, "R4 end"); expect_at(K_WM, 0, "R4 end");
    // R5 read mask latency 2
    rd(BA_A, 0, 1);
    expect_at(K_RB, 0, "R5 before", 1);
    expect_at(K_RB, 1, "R5", 2); expect_at(K_RM, 1, "R5", 2);
    expect_at(K_RB, 1, "R5", 3); expect_at(K_RM, 0, "R5", 3);
    expect_at(K_RB, 1, "R5", 4); expect_at(K_RM, 1, "R5", 4);
    expect_at(K_RB, 1, "R5", 5); expect_at(K_RM, 0, "R5", 5);
    expect_at(K_RB, 0, "R5 end", 6); expect_at(K_RM, 0, "R5 end", 6);
    expect_at(K_ERR, 0, "R5 no error", 6);
    nop(0); nop(1); nop(0); nop(1); nop(1); nop(0);

    // R6 and R12
    do_reset();
    rd(BA_D, 0); expect_at(K_ERR, 1, "R6"); expect_at(K_CODE, 1, "R6");
    act(BA_D); act(BA_D); expect_at(K_CODE, 1, "R12 first kept");
    wr(BA_A, 0); expect_at(K_ERR, 1, "R12 sticky"); expect_at(K_CODE, 1, "R12 sticky");

    // R7
    do_reset();
    act(BA_B); act(BA_B); expect_at(K_ERR, 1, "R7"); expect_at(K_CODE, 2, "R7");

    // R8 legal boundary
    do_reset();
    act(BA_A); act(BA_B);
    wr(BA_A, 1); expect_at(K_OPEN, 4'b0010, "R3 ap close");
    nop(); nop(); nop();
    rd(BA_B, 0); expect_at(K_ERR, 0, "R8 at end of burst");
    // R8 one cycle early
    do_reset();
    act(BA_A); act(BA_B);
    wr(BA_A, 1); nop(); nop();
    rd(BA_B, 0); expect_at(K_ERR, 1, "R8"); expect_at(K_CODE, 3, "R8");

    // R9 legal boundary
    do_reset();
    act(BA_A); rd(BA_A, 1);
    repeat (5) nop();
    act(BA_A); expect_at(K_ERR, 0, "R9 at limit"); expect_at(K_OPEN, 4'b0001, "R9 at limit");
    // R9 one cycle early
    do_reset();
    act(BA_A); rd(BA_A, 1);
    repeat (4) nop();
    act(BA_A); expect_at(K_ERR, 1, "R9"); expect_at(K_CODE, 4, "R9");

    // R10
    do_reset();
    mrs(); expect_at(K_ERR, 0, "R10 mrs idle");
    act(BA_D); mrs(); expect_at(K_CODE, 5, "R10 mrs");
    do_reset();
    act(BA_C); aref(); expect_at(K_CODE, 6, "R10 ref open");
    do_reset();
    act(BA_A); wr(BA_A, 1); aref(); expect_at(K_CODE, 6, "R10 ref cooling");
    do_reset();
    act(BA_B); sref_in(); expect_at(K_CODE, 7, "R10 sref");
    drive(1, 1, 1, 1, 1, 2'b00, 0, 0);

    // R11 and R2 clock-enable gating
    do_reset();
    aref(); expect_at(K_ERR, 0, "R10 ref idle");
    sref_in(); expect_at(K_SREF, 1, "R11 entry"); expect_at(K_ERR, 0, "R11 entry");
    drive(0, 0, 1, 0, 1, BA_A, 0, 0); expect_at(K_ERR, 0, "R2 cke low");
    expect_at(K_SREF, 1, "R11 held");
    drive(1, 1, 1, 1, 1, 2'b00, 0, 0); expect_at(K_SREF, 0, "R11 exit");
    act(BA_A); expect_at(K_OPEN, 4'b0001, "R11 resumed");

    repeat (8) nop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule